// File: doc/BRIEF.md
# NOR Flash Strobe Timing Generator

This block drives the read and write strobes of a parallel NOR flash port that has four active-low chip selects. The host presents one request at a time. Each request gives a chip-select index, a direction, an address and write data. The block asserts the chosen chip select together with the matching strobe for a programmed number of clock cycles. It then deasserts both and pulses a completion flag. For reads, it returns the data sampled from the flash bus.

Timing comes from two pair registers. The first serves chip selects 0 and 1, the second serves 2 and 3. Each pair register holds a 3-bit read width and a 3-bit write width, and a width of zero means sixteen cycles. A control register holds two bits per chip select. One bit allows write cycles on that chip select. The other makes the strobe wait on an external ready line, which is synchronised inside the block. A write to a chip select whose write permission is clear never reaches the flash. It completes immediately with an error flag.

Top module: `nor_strobe_gen`

## Requirements
- R1: After reset, all chip selects and both strobes are high, `req_ready_o` is 1, and all three configuration registers read 0.
- R2: Configuration address 0 is the control register. Bit n permits writes on chip select n and bit 4+n enables ready checking on chip select n. Bits [31:8] read 0 and ignore writes. Address 1 holds the timing for chip selects 0/1 and address 2 the timing for chip selects 2/3. In each, bits [2:0] are the read width and bits [6:4] the write width, and every other bit reads 0.
- R3: During a cycle, only the requested chip select goes low, and at most one chip select is low at a time. Only the strobe for the request's direction goes low, and only while that chip select is low.
- R4: With ready checking disabled for the chip select, the strobe stays low for exactly the programmed width, taken from that chip select's pair register and direction field.
- R5: A programmed width of 0 gives a strobe of 16 cycles.
- R6: A write request to a chip select whose write-permit bit is 0 produces `done_o` and `err_o` in the cycle after acceptance. No chip select and no write strobe goes low.
- R7: With ready checking enabled and the ready line steadily high, the strobe lasts the programmed width plus 2 cycles.
- R8: With ready checking enabled and the ready line low, the strobe is held low. It rises on the first cycle that the two-stage-synchronised ready is high, once at least width+2 cycles have passed.
- R9: A low ready line has no effect on a chip select whose ready-check bit is 0.
- R10: `done_o` pulses for one cycle, in the cycle the strobe rises. `err_o` is 0 on a completed cycle. On reads, `rdata_o` then holds the flash data sampled in the last strobe cycle. On writes, `flash_data_o` carries the request data with `flash_data_oe_o` high while the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Read-back of the selected register |
| req_valid_i | input | 1 | Request present (taken when idle) |
| req_cs_i | input | 2 | Target chip-select index |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Flash address |
| req_wdata_i | input | 16 | Write data |
| req_ready_o | output | 1 | Block idle, request accepted this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion was a blocked write |
| rdata_o | output | 16 | Read data, valid with done_o |
| flash_cs_no | output | 4 | Chip selects, active low |
| flash_re_no | output | 1 | Read strobe, active low |
| flash_we_no | output | 1 | Write strobe, active low |
| flash_addr_o | output | 16 | Flash address bus |
| flash_data_o | output | 16 | Flash write data |
| flash_data_oe_o | output | 1 | Flash data output enable |
| flash_data_i | input | 16 | Flash read data |
| flash_rdy_i | input | 1 | External channel-ready line |

## Verification
Strobe lengths are measured for reads and writes on different chip selects with distinct nonzero widths. This tells apart the field and pair that each request must pick. A zero field tells the sixteen-cycle substitution apart from a literal zero or seven. The ready line is driven three ways: steadily high, held low and released late, and held low on a chip select that does not check it. These separate the fixed two-cycle extension, the synchroniser delay and the per-chip-select gating. A write to a chip select without write permission, sitting next to one that has it, shows that blocking is decided per chip select.

// File: rtl/nor_strobe_pkg.sv
package nor_strobe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STB  = 2'd1,
    ST_EXT  = 2'd2,
    ST_DONE = 2'd3
  } state_e;

  localparam int CFG_DW    = 32;
  localparam int RD_LSB    = 0;
  localparam int WR_LSB    = 4;
endpackage

// File: rtl/nor_cfg_regs.sv
module nor_cfg_regs
  import nor_strobe_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CW     = 3,
  localparam int NPAIR = NUM_CS / 2,
  localparam int CAW   = $clog2(NPAIR + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [CAW-1:0]               cfg_addr_i,
  input  logic [CFG_DW-1:0]            cfg_wdata_i,
  output logic [CFG_DW-1:0]            cfg_rdata_o,
  output logic [NUM_CS-1:0]            we_en_o,
  output logic [NUM_CS-1:0]            chk_en_o,
  output logic [NUM_CS-1:0][CW-1:0]    rd_w_o,
  output logic [NUM_CS-1:0][CW-1:0]    wr_w_o
);
  logic [NUM_CS-1:0] we_q, chk_q;
  logic [NPAIR-1:0][CW-1:0] prd_q, pwr_q;
  logic [NPAIR:0][CFG_DW-1:0] rd_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q  <= '0;
      chk_q <= '0;
    end else if (cfg_we_i && cfg_addr_i == '0) begin
      we_q  <= cfg_wdata_i[NUM_CS-1:0];
      chk_q <= cfg_wdata_i[2*NUM_CS-1:NUM_CS];
    end
  end

  always_comb begin
    rd_vec[0] = '0;
    rd_vec[0][NUM_CS-1:0]        = we_q;
    rd_vec[0][2*NUM_CS-1:NUM_CS] = chk_q;
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prd_q[p] <= '0;
        pwr_q[p] <= '0;
      end else if (cfg_we_i && cfg_addr_i == CAW'(p + 1)) begin
        prd_q[p] <= cfg_wdata_i[RD_LSB +: CW];
        pwr_q[p] <= cfg_wdata_i[WR_LSB +: CW];
      end
    end

    always_comb begin
      rd_vec[p+1] = '0;
      rd_vec[p+1][RD_LSB +: CW] = prd_q[p];
      rd_vec[p+1][WR_LSB +: CW] = pwr_q[p];
    end

    assign rd_w_o[2*p]   = prd_q[p];
    assign rd_w_o[2*p+1] = prd_q[p];
    assign wr_w_o[2*p]   = pwr_q[p];
    assign wr_w_o[2*p+1] = pwr_q[p];
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int i = 0; i <= NPAIR; i++)
      if (cfg_addr_i == CAW'(i)) cfg_rdata_o = rd_vec[i];
  end

  assign we_en_o  = we_q;
  assign chk_en_o = chk_q;
endmodule

// File: rtl/nor_rdy_sync.sv
module nor_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/nor_strobe_fsm.sv
module nor_strobe_fsm
  import nor_strobe_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CW     = 3,
  parameter int AW     = 16,
  parameter int DW     = 16,
  localparam int CSW   = $clog2(NUM_CS),
  localparam int EW    = CW + 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [CSW-1:0]             req_cs_i,
  input  logic                       req_write_i,
  input  logic [AW-1:0]              req_addr_i,
  input  logic [DW-1:0]              req_wdata_i,
  output logic                       req_ready_o,
  output logic                       done_o,
  output logic                       err_o,
  output logic [DW-1:0]              rdata_o,
  input  logic [NUM_CS-1:0]          we_en_i,
  input  logic [NUM_CS-1:0]          chk_en_i,
  input  logic [NUM_CS-1:0][CW-1:0]  rd_w_i,
  input  logic [NUM_CS-1:0][CW-1:0]  wr_w_i,
  input  logic                       rdy_s_i,
  output logic [NUM_CS-1:0]          flash_cs_no,
  output logic                       flash_re_no,
  output logic                       flash_we_no,
  output logic [AW-1:0]              flash_addr_o,
  output logic [DW-1:0]              flash_data_o,
  output logic                       flash_data_oe_o,
  input  logic [DW-1:0]              flash_data_i
);
  state_e          state_q;
  logic [CSW-1:0]  cs_q;
  logic            wr_q, chk_q, ext_q, err_q;
  logic [EW-1:0]   cnt_q, eff_q, eff_d;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q, rdata_q;
  logic [CW-1:0]   sel_w;
  logic            active, blocked;

  // zero field selects the longest width
  assign sel_w   = req_write_i ? wr_w_i[req_cs_i] : rd_w_i[req_cs_i];
  assign eff_d   = (sel_w == '0) ? (EW'(1) << (CW + 1)) : EW'(sel_w);
  assign blocked = req_write_i && !we_en_i[req_cs_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= '0;
      wr_q    <= 1'b0;
      chk_q   <= 1'b0;
      ext_q   <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      eff_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          cs_q    <= req_cs_i;
          wr_q    <= req_write_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          cnt_q   <= EW'(1);
          eff_q   <= eff_d;
          chk_q   <= chk_en_i[req_cs_i];
          err_q   <= blocked;
          state_q <= blocked ? ST_DONE : ST_STB;
        end
        ST_STB: begin
          if (cnt_q == eff_q) begin
            if (chk_q) begin
              ext_q   <= 1'b0;
              state_q <= ST_EXT;
            end else begin
              rdata_q <= flash_data_i;
              state_q <= ST_DONE;
            end
          end else begin
            cnt_q <= cnt_q + EW'(1);
          end
        end
        ST_EXT: begin
          // at least two extra cycles, then wait on synchronised ready
          if (ext_q && rdy_s_i) begin
            rdata_q <= flash_data_i;
            state_q <= ST_DONE;
          end else begin
            ext_q <= 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active          = (state_q == ST_STB) || (state_q == ST_EXT);
  assign req_ready_o     = (state_q == ST_IDLE);
  assign done_o          = (state_q == ST_DONE);
  assign err_o           = done_o && err_q;
  assign rdata_o         = rdata_q;
  assign flash_re_no     = !(active && !wr_q);
  assign flash_we_no     = !(active && wr_q);
  assign flash_addr_o    = addr_q;
  assign flash_data_o    = wdata_q;
  assign flash_data_oe_o = active && wr_q;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign flash_cs_no[i] = !(active && cs_q == CSW'(i));
  end
endmodule

// File: rtl/nor_strobe_gen.sv
module nor_strobe_gen
  import nor_strobe_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int CW      = 3,
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int SYNC_ST = 2,
  localparam int CSW    = $clog2(NUM_CS),
  localparam int CAW    = $clog2(NUM_CS / 2 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CAW-1:0]    cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic [CSW-1:0]    req_cs_i,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_CS-1:0] flash_cs_no,
  output logic              flash_re_no,
  output logic              flash_we_no,
  output logic [AW-1:0]     flash_addr_o,
  output logic [DW-1:0]     flash_data_o,
  output logic              flash_data_oe_o,
  input  logic [DW-1:0]     flash_data_i,
  input  logic              flash_rdy_i
);
  logic [NUM_CS-1:0]         we_en, chk_en;
  logic [NUM_CS-1:0][CW-1:0] rd_w, wr_w;
  logic                      rdy_s;

  nor_cfg_regs #(.NUM_CS(NUM_CS), .CW(CW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .we_en_o     (we_en),
    .chk_en_o    (chk_en),
    .rd_w_o      (rd_w),
    .wr_w_o      (wr_w)
  );

  nor_rdy_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (flash_rdy_i),
    .q_o    (rdy_s)
  );

  nor_strobe_fsm #(.NUM_CS(NUM_CS), .CW(CW), .AW(AW), .DW(DW)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_cs_i        (req_cs_i),
    .req_write_i     (req_write_i),
    .req_addr_i      (req_addr_i),
    .req_wdata_i     (req_wdata_i),
    .req_ready_o     (req_ready_o),
    .done_o          (done_o),
    .err_o           (err_o),
    .rdata_o         (rdata_o),
    .we_en_i         (we_en),
    .chk_en_i        (chk_en),
    .rd_w_i          (rd_w),
    .wr_w_i          (wr_w),
    .rdy_s_i         (rdy_s),
    .flash_cs_no     (flash_cs_no),
    .flash_re_no     (flash_re_no),
    .flash_we_no     (flash_we_no),
    .flash_addr_o    (flash_addr_o),
    .flash_data_o    (flash_data_o),
    .flash_data_oe_o (flash_data_oe_o),
    .flash_data_i    (flash_data_i)
  );
endmodule

// File: rtl/nor_strobe_gen_chk.sv
module nor_strobe_gen_chk #(
  parameter int NUM_CS = 4,
  localparam int CSW   = $clog2(NUM_CS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_write_i,
  input logic [CSW-1:0]    req_cs_i,
  input logic [NUM_CS-1:0] we_en,
  input logic [NUM_CS-1:0] flash_cs_no,
  input logic              flash_re_no,
  input logic              flash_we_no,
  input logic              done_o,
  input logic              err_o
);
  p_cs_onehot0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~flash_cs_no) <= 1);

  p_strobe_needs_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_re_no || !flash_we_no) |-> (flash_cs_no != '1) && (flash_re_no || flash_we_no));

  p_blocked_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_write_i && !we_en[req_cs_i])
      |=> (done_o && err_o && flash_cs_no == '1 && flash_we_no));

  p_done_on_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flash_re_no) || $rose(flash_we_no)) |-> (done_o && !err_o));

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind nor_strobe_gen nor_strobe_gen_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_write_i (req_write_i),
  .req_cs_i    (req_cs_i),
  .we_en       (we_en),
  .flash_cs_no (flash_cs_no),
  .flash_re_no (flash_re_no),
  .flash_we_no (flash_we_no),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/nor_strobe_gen_tb_top.sv
module nor_strobe_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_cs_i = '0;
  logic        req_write_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        req_ready_o, done_o, err_o;
  logic [15:0] rdata_o;
  logic [3:0]  flash_cs_no;
  logic        flash_re_no, flash_we_no, flash_data_oe_o;
  logic [15:0] flash_addr_o, flash_data_o;
  logic [15:0] flash_data_i = 16'hA5C3;
  logic        flash_rdy_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  nor_strobe_gen dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1 d = cfg_rdata_o;
  endtask

  // issue one request, count strobe-low cycles, return completion info
  task automatic run_req(input logic [1:0] cs, input bit wr, input logic [15:0] data,
                         input int rdy_at, output int low, output bit err, output logic [15:0] rd);
    bit fin = 0;
    bit bad_cs = 0, bad_other = 0, bad_data = 0;
    low = 0; err = 0; rd = '0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_cs_i = cs; req_write_i = wr;
    req_addr_i = 16'h1234; req_wdata_i = data;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int i = 0; i < 100 && !fin; i++) begin
      if (done_o) begin
        fin = 1; err = err_o; rd = rdata_o;
      end else begin
        if (wr ? !flash_we_no : !flash_re_no) begin
          low++;
          if (flash_cs_no != ~(4'b1 << cs)) bad_cs = 1;
          if (wr && (!flash_data_oe_o || flash_data_o != data)) bad_data = 1;
        end
        if (wr ? !flash_re_no : !flash_we_no) bad_other = 1;
        if (rdy_at != 0 && low == rdy_at) flash_rdy_i = 1'b1;
        @(negedge clk_i);
      end
    end
    chk(fin, "R10 done seen", fin, 1);
    chk(!bad_cs, "R3 chip select pattern", bad_cs, 0);
    chk(!bad_other, "R3 opposite strobe quiet", bad_other, 0);
    if (wr) chk(!bad_data, "R10 write data driven", bad_data, 0);
    @(negedge clk_i);
    chk(!done_o, "R10 done single pulse", done_o, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(flash_cs_no == 4'hF, "R1 cs idle", flash_cs_no, 4'hF);
    chk(flash_re_no && flash_we_no, "R1 strobes idle", {flash_re_no, flash_we_no}, 3);
    chk(req_ready_o, "R1 ready", req_ready_o, 1);
    for (int a = 0; a < 3; a++) begin
      cfg_rd(2'(a), d);
      chk(d == 0, "R1 cfg reset", d, 0);
    end
  endtask

  task automatic t_default16;
    int low; bit err; logic [15:0] rd;
    run_req(2'd0, 1'b0, 16'h0, 0, low, err, rd);
    chk(low == 16, "R5 default width 16", low, 16);
    chk(!err, "R10 no error", err, 0);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    cfg_wr(2'd0, 32'hFFFF_FFFF);
    cfg_rd(2'd0, d);
    chk(d == 32'hFF, "R2 ctrl reserved", d, 32'hFF);
    cfg_wr(2'd1, 32'hFFFF_FFFF);
    cfg_rd(2'd1, d);
    chk(d == 32'h77, "R2 timing01 fields", d, 32'h77);
    // CS0 and CS3 may write, CS2 checks ready
    cfg_wr(2'd0, 32'h0000_0049);
    cfg_wr(2'd1, 32'h0000_0053);
    cfg_wr(2'd2, 32'hFFFF_FF02);
    cfg_rd(2'd2, d);
    chk(d == 32'h02, "R2 timing23 fields", d, 32'h02);
    cfg_rd(2'd0, d);
    chk(d == 32'h49, "R2 ctrl value", d, 32'h49);
  endtask

  task automatic t_read_w;
    int low; bit err; logic [15:0] rd;
    run_req(2'd1, 1'b0, 16'h0, 0, low, err, rd);
    chk(low == 3, "R4 read width cs1", low, 3);
    chk(rd == 16'hA5C3, "R10 read data", rd, 16'hA5C3);
    chk(!err, "R10 no error read", err, 0);
  endtask

  task automatic t_write_w;
    int low; bit err; logic [15:0] rd;
    run_req(2'd0, 1'b1, 16'h5A0F, 0, low, err, rd);
    chk(low == 5, "R4 write width cs0", low, 5);
    chk(!err, "R10 no error write", err, 0);
  endtask

  task automatic t_blocked;
    int low; bit err; logic [15:0] rd;
    run_req(2'd1, 1'b1, 16'hBEEF, 0, low, err, rd);
    chk(low == 0, "R6 blocked no strobe", low, 0);
    chk(err, "R6 blocked error", err, 1);
  endtask

  task automatic t_rdy_high;
    int low; bit err; logic [15:0] rd;
    flash_rdy_i = 1'b1;
    repeat (3) @(negedge clk_i);
    run_req(2'd2, 1'b0, 16'h0, 0, low, err, rd);
    chk(low == 4, "R7 ready high adds two", low, 4);
  endtask

  task automatic t_rdy_late;
    int low; bit err; logic [15:0] rd;
    flash_rdy_i = 1'b0;
    repeat (3) @(negedge clk_i);
    run_req(2'd2, 1'b0, 16'h0, 6, low, err, rd);
    chk(low == 8, "R8 ready late release", low, 8);
  endtask

  task automatic t_rdy_ignored;
    int low; bit err; logic [15:0] rd;
    flash_rdy_i = 1'b0;
    repeat (3) @(negedge clk_i);
    run_req(2'd3, 1'b0, 16'h0, 0, low, err, rd);
    chk(low == 2, "R9 ready ignored cs3", low, 2);
    run_req(2'd3, 1'b1, 16'h0F0F, 0, low, err, rd);
    chk(low == 16, "R5 write field zero cs3", low, 16);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_default16();
    t_cfg();
    t_read_w();
    t_write_w();
    t_blocked();
    t_rdy_high();
    t_rdy_late();
    t_rdy_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule